// File: doc/BRIEF.md
# Virtually Addressed Read Cache

This block is a read-only data cache that sits between a processor load port and physical memory. It selects the set and compares the tag using only the virtual address. A lookup that hits therefore returns its byte with no address translation at all. Only on a miss does the cache send the virtual address to a translation unit. A valid translation leads to a line fetch from memory, the line is installed, and the requested byte is returned. A translation that reports a page fault ends the request with a fault status, and nothing is allocated.

The default geometry is 1 KB: 4 ways of 16 sets with 16-byte lines and a 16-bit virtual address. The address splits into byte offset [3:0], set index [7:4] and tag [15:8]. Pages are 4 KB, so the translation unit returns a 4-bit physical page number. The cache handles one request at a time. Every data port uses valid/ready. A payload is offered by raising valid and is held unchanged until the cycle in which ready is also high. A receiver that keeps ready low stalls the cache in its current step without losing anything.

Top module: `vcache_top`

## Requirements
- R1: After reset no line is valid, req_ready is high, and rsp_valid, xlat_req_valid and mem_req_valid are low. The first access to any address after reset misses.
- R2: The set is selected by vaddr[7:4] and the tag is vaddr[15:8]. Addresses that share a set but differ in tag occupy separate ways and do not alias.
- R3: A hit returns the byte at offset vaddr[3:0] with rsp_kind = 0 (hit, translation not accessed). xlat_req_valid is never raised for it.
- R4: A miss raises xlat_req_valid with xlat_req_vaddr equal to the request address. On a valid translation with page number P, mem_req_addr = {P, vaddr[11:4], 4'b0000}.
- R5: In a fill line, byte k lies at mem_rsp_line[8k+7:8k]. The cache stores the whole line and returns byte vaddr[3:0] of it with rsp_kind = 1 (miss, translated). Later accesses to any byte of that line hit.
- R6: When xlat_rsp_fault is high, the response has rsp_kind = 2 (fault) and no memory request is made. No line is installed, so repeating the access misses and faults again.
- R7: A miss fills the lowest-numbered invalid way of its set. If every way is valid, the least recently used way is replaced.
- R8: A hit makes its way the most recently used, which changes the victim chosen by later misses in that set.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_data and rsp_kind hold their values.
- R10: Once a request is accepted, req_ready stays low until its response has been taken.
- R11: While a translation or memory request waits for ready, its valid and address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Cache can accept a load |
| req_vaddr | input | 16 | Virtual byte address |
| rsp_valid | output | 1 | Load response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 8 | Loaded byte (zero on fault) |
| rsp_kind | output | 2 | 0 hit, 1 translated miss, 2 fault |
| xlat_req_valid | output | 1 | Translation request offered |
| xlat_req_ready | input | 1 | Translation unit takes the request |
| xlat_req_vaddr | output | 16 | Address to translate |
| xlat_rsp_valid | input | 1 | Translation result offered |
| xlat_rsp_ready | output | 1 | Cache takes the result |
| xlat_rsp_ppn | input | 4 | Physical page number |
| xlat_rsp_fault | input | 1 | Page not mapped |
| mem_req_valid | output | 1 | Line read offered |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 16 | Line-aligned physical address |
| mem_rsp_valid | input | 1 | Line data offered |
| mem_rsp_ready | output | 1 | Cache takes the line |
| mem_rsp_line | input | 128 | Line data, byte k at bits [8k+7:8k] |

## Verification
The bench drives long runs of accesses into one set, so that LRU order decides every eviction. A design that aged the wrong ways, ignored hits when updating recency, or preferred an old valid way over an empty one would report a hit where a miss is expected, or the reverse. Faulting addresses are sent twice to the same line. A design that allocated on a fault would return a hit the second time. Every port is also stalled for several cycles while the bench watches that the payload holds and that no new request is accepted. A reset in the middle of the run must turn a previously cached line back into a miss.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_XREQ, ST_XWAIT, ST_MREQ, ST_MWAIT, ST_RESP
  } vc_state_e;

  typedef enum logic [1:0] {
    RK_HIT   = 2'd0,
    RK_MISS  = 2'd1,
    RK_FAULT = 2'd2
  } vc_kind_e;
endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       idx,
  input  logic [TAG_W-1:0]              tag,
  input  logic                          wr_en,
  input  logic [$clog2(WAYS)-1:0]       wr_way,
  output logic [WAYS-1:0]               hit_vec,
  output logic [WAYS-1:0]               valid_vec
);
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [TAG_W-1:0] tags_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags_q[idx][wr_way] <= tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[idx][w] && (tags_q[idx][w] == tag);
  end
  assign valid_vec = vld_q[idx];

  // R2: a tag never lives in two ways of one set
  a_r2_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] idx,
  input  logic [WAYS-1:0]         valid_vec,
  input  logic                    upd_en,
  input  logic [$clog2(WAYS)-1:0] upd_way,
  output logic [$clog2(WAYS)-1:0] victim_way
);
  localparam int AGE_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(SETS);

  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic             found;
  logic [WAYS-1:0]  is_oldest;

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign is_oldest[w] = (age_q[idx][w] == AGE_W'(WAYS - 1));
  end

  always_comb begin
    victim_way = '0;
    found      = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_vec[w] && !found) begin
        victim_way = AGE_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (is_oldest[w]) victim_way = AGE_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == upd_way)
          age_q[idx][w] <= '0;
        else if (age_q[idx][w] < age_q[idx][upd_way])
          age_q[idx][w] <= age_q[idx][w] + 1'b1;
      end
    end
  end

  logic             chk_pend;
  logic [IDX_W-1:0] chk_idx;
  logic [AGE_W-1:0] chk_way;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_pend <= 1'b0;
      chk_idx  <= '0;
      chk_way  <= '0;
    end else begin
      chk_pend <= upd_en;
      chk_idx  <= idx;
      chk_way  <= upd_way;
    end
  end

  // R8: the way just touched is the youngest of its set
  a_r8_touched_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pend |-> (age_q[chk_idx][chk_way] == '0));
  // R7: the ages of a set stay a permutation, so one way is always oldest
  a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/vc_line_store.sv
module vc_line_store #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int LINE_W = 128
) (
  input  logic                    clk,
  input  logic [$clog2(SETS)-1:0] idx,
  input  logic [$clog2(WAYS)-1:0] rd_way,
  output logic [LINE_W-1:0]       rd_line,
  input  logic                    wr_en,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic [LINE_W-1:0]       wr_line
);
  logic [LINE_W-1:0] lines_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) lines_q[idx][wr_way] <= wr_line;
  end

  assign rd_line = lines_q[idx][rd_way];
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int VA_W       = 16,
  parameter int PA_W       = 16,
  parameter int PAGE_W     = 12,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 16,
  parameter int WAYS       = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [VA_W-1:0]               req_vaddr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [7:0]                    rsp_data,
  output logic [1:0]                    rsp_kind,
  output logic                          xlat_req_valid,
  input  logic                          xlat_req_ready,
  output logic [VA_W-1:0]               xlat_req_vaddr,
  input  logic                          xlat_rsp_valid,
  output logic                          xlat_rsp_ready,
  input  logic [PA_W-PAGE_W-1:0]        xlat_rsp_ppn,
  input  logic                          xlat_rsp_fault,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_rsp_valid,
  output logic                          mem_rsp_ready,
  input  logic [LINE_BYTES*8-1:0]       mem_rsp_line
);
  import vc_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = VA_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int PPN_W  = PA_W - PAGE_W;

  vc_state_e         st_q;
  vc_kind_e          kind_q;
  logic [7:0]        data_q;
  logic [VA_W-1:0]   va_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [WAY_W-1:0]  victim_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;
  logic [WAYS-1:0]   hit_vec, valid_vec;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim_way, upd_way;
  logic [LINE_W-1:0] rd_line;
  logic              fill_en, upd_en, lookup_hit;

  assign idx = va_q[OFF_W +: IDX_W];
  assign tag = va_q[VA_W-1 -: TAG_W];
  assign off = va_q[OFF_W-1:0];

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] ln,
                                           input logic [OFF_W-1:0] o);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < LINE_BYTES; k++)
      if (OFF_W'(k) == o) r = ln[8*k +: 8];
    return r;
  endfunction

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit = |hit_vec;

  assign lookup_hit = (st_q == ST_LOOKUP) && hit;
  assign fill_en    = (st_q == ST_MWAIT) && mem_rsp_valid;
  assign upd_en     = lookup_hit || fill_en;
  assign upd_way    = fill_en ? victim_q : hit_way;

  vc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(idx), .tag(tag),
    .wr_en(fill_en), .wr_way(victim_q),
    .hit_vec(hit_vec), .valid_vec(valid_vec)
  );

  vc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .idx(idx), .valid_vec(valid_vec),
    .upd_en(upd_en), .upd_way(upd_way), .victim_way(victim_way)
  );

  vc_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .idx(idx), .rd_way(hit_way), .rd_line(rd_line),
    .wr_en(fill_en), .wr_way(victim_q), .wr_line(mem_rsp_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= RK_HIT;
      data_q   <= '0;
      va_q     <= '0;
      ppn_q    <= '0;
      victim_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          st_q <= ST_LOOKUP;
        end
        ST_LOOKUP: if (hit) begin
          data_q <= pick_byte(rd_line, off);
          kind_q <= RK_HIT;
          st_q   <= ST_RESP;
        end else begin
          victim_q <= victim_way;
          st_q     <= ST_XREQ;
        end
        ST_XREQ: if (xlat_req_ready) st_q <= ST_XWAIT;
        ST_XWAIT: if (xlat_rsp_valid) begin
          if (xlat_rsp_fault) begin
            kind_q <= RK_FAULT;
            data_q <= '0;
            st_q   <= ST_RESP;
          end else begin
            ppn_q <= xlat_rsp_ppn;
            st_q  <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          data_q <= pick_byte(mem_rsp_line, off);
          kind_q <= RK_MISS;
          st_q   <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign rsp_valid      = (st_q == ST_RESP);
  assign rsp_data       = data_q;
  assign rsp_kind       = kind_q;
  assign xlat_req_valid = (st_q == ST_XREQ);
  assign xlat_req_vaddr = va_q;
  assign xlat_rsp_ready = (st_q == ST_XWAIT);
  assign mem_req_valid  = (st_q == ST_MREQ);
  assign mem_req_addr   = {ppn_q, va_q[PAGE_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_rsp_ready  = (st_q == ST_MWAIT);

  // R3: a hit goes straight to a response, never to translation
  a_r3_hit_no_xlat: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (rsp_valid && !xlat_req_valid && rsp_kind == RK_HIT));
  // R6: a fault answers at once and never reaches memory
  a_r6_fault_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_rsp_valid && xlat_rsp_ready && xlat_rsp_fault)
      |=> (rsp_valid && !mem_req_valid && rsp_kind == RK_FAULT));
  // R9: response payload holds under back-pressure
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_kind)));
  // R10: no second request while one is in flight
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11: translation and memory requests hold while stalled
  a_r11_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req_valid && !xlat_req_ready) |=> (xlat_req_valid && $stable(xlat_req_vaddr)));
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/sim_vcache_top.sv
`timescale 1ns/1ps
module sim_vcache_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready;
  logic [15:0]  req_vaddr;
  logic         rsp_valid, rsp_ready;
  logic [7:0]   rsp_data;
  logic [1:0]   rsp_kind;
  logic         xlat_req_valid, xlat_req_ready;
  logic [15:0]  xlat_req_vaddr;
  logic         xlat_rsp_valid, xlat_rsp_ready;
  logic [3:0]   xlat_rsp_ppn;
  logic         xlat_rsp_fault;
  logic         mem_req_valid, mem_req_ready;
  logic [15:0]  mem_req_addr;
  logic         mem_rsp_valid, mem_rsp_ready;
  logic [127:0] mem_rsp_line;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  vcache_top u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
    .xlat_req_valid(xlat_req_valid), .xlat_req_ready(xlat_req_ready),
    .xlat_req_vaddr(xlat_req_vaddr), .xlat_rsp_valid(xlat_rsp_valid),
    .xlat_rsp_ready(xlat_rsp_ready), .xlat_rsp_ppn(xlat_rsp_ppn),
    .xlat_rsp_fault(xlat_rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_line(mem_rsp_line)
  );

  // address, expected kind (0 hit, 1 miss, 2 fault)
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    {16'h002f, 2'd1}, {16'h1020, 2'd1}, {16'hfba8, 2'd2}, {16'hae26, 2'd1},
    {16'hcf2a, 2'd2}, {16'hdbaf, 2'd1}, {16'hae2f, 2'd0}, {16'hfca1, 2'd2},
    {16'h102b, 2'd0}, {16'h0020, 2'd0}, {16'h3021, 2'd1}, {16'h4025, 2'd1},
    {16'hae20, 2'd1}, {16'h0021, 2'd0}, {16'h5022, 2'd1}, {16'h3020, 2'd1},
    {16'h002e, 2'd0}, {16'h4020, 2'd1}, {16'hae2a, 2'd1}, {16'h2025, 2'd2},
    {16'h202f, 2'd2}, {16'h402f, 2'd0}, {16'h5020, 2'd1}, {16'h9a77, 2'd1},
    {16'h9a70, 2'd0}
  };

  function automatic logic [4:0] page_map(input logic [3:0] vpn);
    case (vpn)
      4'h0: return {1'b1, 4'h1};
      4'h1: return {1'b1, 4'ha};
      4'h3: return {1'b1, 4'h0};
      4'h4: return {1'b1, 4'h8};
      4'h5: return {1'b1, 4'hb};
      4'h8: return {1'b1, 4'h3};
      4'h9: return {1'b1, 4'h5};
      4'ha: return {1'b1, 4'h6};
      4'hb: return {1'b1, 4'hc};
      4'hd: return {1'b1, 4'hf};
      default: return {1'b0, 4'h0};
    endcase
  endfunction

  function automatic logic [7:0] mem_byte(input logic [11:0] pline, input int k);
    return (pline[7:0] + 8'(k * 29)) ^ {pline[11:8], pline[11:8]};
  endfunction

  function automatic logic [127:0] mem_line(input logic [11:0] pline);
    logic [127:0] l;
    for (int k = 0; k < 16; k++) l[8*k +: 8] = mem_byte(pline, k);
    return l;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic access(input logic [15:0] va, input logic [1:0] ek, input int stall);
    int g;
    logic [4:0]  pm;
    logic [15:0] pa;
    bit          saw_x;
    pm = page_map(va[15:12]);
    pa = {pm[3:0], va[11:0]};
    saw_x = 1'b0;
    req_valid = 1'b1;
    req_vaddr = va;
    g = 0;
    while (!req_ready && g < 50) begin @(negedge clk); g++; end
    @(negedge clk);
    req_valid = 1'b0;
    g = 0;
    while (!xlat_req_valid && !rsp_valid && g < 50) begin @(negedge clk); g++; end
    if (xlat_req_valid) begin
      saw_x = 1'b1;
      chk(xlat_req_vaddr == va, "R4", "translate address", 32'(xlat_req_vaddr), 32'(va));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(xlat_req_valid && xlat_req_vaddr == va, "R11", "translate hold",
            32'(xlat_req_vaddr), 32'(va));
      end
      xlat_req_ready = 1'b1;
      @(negedge clk);
      xlat_req_ready = 1'b0;
      xlat_rsp_valid = 1'b1;
      xlat_rsp_ppn   = pm[3:0];
      xlat_rsp_fault = !pm[4];
      g = 0;
      while (!xlat_rsp_ready && g < 50) begin @(negedge clk); g++; end
      @(negedge clk);
      xlat_rsp_valid = 1'b0;
      if (!pm[4]) begin
        chk(!mem_req_valid && rsp_valid, "R6", "fault skips memory",
            32'(mem_req_valid), 32'h0);
      end else begin
        chk(mem_req_valid && mem_req_addr == {pa[15:4], 4'h0}, "R4", "memory address",
            32'(mem_req_addr), 32'({pa[15:4], 4'h0}));
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == {pa[15:4], 4'h0}, "R11", "memory hold",
              32'(mem_req_addr), 32'({pa[15:4], 4'h0}));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_line  = mem_line(pa[15:4]);
        g = 0;
        while (!mem_rsp_ready && g < 50) begin @(negedge clk); g++; end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
    g = 0;
    while (!rsp_valid && g < 50) begin @(negedge clk); g++; end
    chk(rsp_kind == ek, (ek == 2'd0) ? "R3" : (ek == 2'd1) ? "R5" : "R6",
        $sformatf("kind for %h", va), 32'(rsp_kind), 32'(ek));
    chk(saw_x == (ek != 2'd0), "R3", $sformatf("translation used for %h", va),
        32'(saw_x), 32'(ek != 2'd0));
    if (ek != 2'd2)
      chk(rsp_data == mem_byte(pa[15:4], int'(va[3:0])), "R5",
          $sformatf("data for %h", va), 32'(rsp_data),
          32'(mem_byte(pa[15:4], int'(va[3:0]))));
    for (int s = 0; s < stall; s++) begin
      logic [7:0] d0;
      d0 = rsp_data;
      @(negedge clk);
      chk(rsp_valid && rsp_data == d0, "R9", "response hold", 32'(rsp_data), 32'(d0));
      chk(!req_ready, "R10", "no accept while busy", 32'(req_ready), 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    req_valid = 0; req_vaddr = '0; rsp_ready = 0;
    xlat_req_ready = 0; xlat_rsp_valid = 0; xlat_rsp_ppn = '0; xlat_rsp_fault = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_line = '0;
    do_reset();
    // R1: idle outputs after reset
    chk(req_ready && !rsp_valid && !xlat_req_valid && !mem_req_valid, "R1",
        "reset state", {28'h0, req_ready, rsp_valid, xlat_req_valid, mem_req_valid},
        32'h8);

    // R2 R7 R8: one set filled past its ways, order decided by recency
    for (int i = 0; i < NV; i++)
      access(VEC[i][17:2], VEC[i][1:0], i % 3);

    // R6: repeated fault on one line still misses and faults
    access(16'h2021, 2'd2, 1);
    // R5: another byte of a filled line hits
    access(16'h9a7f, 2'd0, 0);

    // R1: reset clears all lines
    do_reset();
    chk(req_ready && !rsp_valid, "R1", "state after second reset",
        {30'h0, req_ready, rsp_valid}, 32'h2);
    access(16'h9a70, 2'd1, 0);
    access(16'h9a71, 2'd0, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule